// File: doc/BRIEF.md
# Multi-Mode Serial Port Controller

This block is a byte-wide serial port with four operating modes, selected by two bits in its control register. Mode 0 is a synchronous shifter: the block drives its own shift clock, divided down from the system clock, and moves eight bits in either direction. Mode 1 sends and receives asynchronous frames with eight data bits. Modes 2 and 3 add a ninth bit, which serves as an address marker when several nodes share one line. In this block, modes 2 and 3 behave the same way, because the baud source is supplied from outside.

Software reaches the port through two byte locations: a control register and a data location. Writing the data location loads the transmitter and starts a frame. Reading it returns a separate receive holding register. A receive flag and a transmit flag record completed transfers and stay set until software clears them, and the interrupt output follows them. For asynchronous timing the block counts an external baud tick that runs at sixteen times the bit rate. A separate enable input turns the top control bit from a mode bit into a sticky framing-error flag.

Top module: `sport_multimode`

## Requirements
- R1: After reset, both the control register and the receive holding register read 00h, txd and sclk are 1, and irq is 0.
- R2: `addr`=0 selects control and `addr`=1 selects data. `rdata` is 00h whenever `rd_en` is 0. The control bits are: bit0 receive flag, bit1 transmit flag, bit2 received ninth bit, bit3 ninth bit to send, bit4 receive enable, bit5 SM2, bit6 mode bit 1, bit7 mode bit 0 (or the framing-error flag). The mode is {bit7, bit6}: 00 is mode 0, 01 is mode 1, 10 is mode 2 and 11 is mode 3. Software can write every bit.
- R3: In modes 1 to 3, writing data sends a start bit of 0, then eight data bits LSB first, then (in modes 2 and 3 only) the ninth bit from bit3, then a stop bit of 1. Each bit lasts 16 baud ticks. A data write made while a frame is in progress is dropped.
- R4: The transmit flag sets when the last data bit ends. In modes 1 to 3 that bit is the eighth or the ninth; in mode 0 it is the eighth. Both flags stay set until a control write clears them, and a hardware set beats a write in the same cycle.
- R5: The receiver samples each bit at baud ticks 7, 8 and 9 after it detects the start, and takes the majority. If the start bit reads 1 at mid-bit, the receiver drops back to idle.
- R6: In mode 1 the receive flag sets after the stop-bit sample. With SM2=0 the frame is always accepted and bit2 takes the stop bit. With SM2=1, a frame whose stop bit is 0 leaves the flags, bit2 and the holding register unchanged.
- R7: In modes 2 and 3 the receive flag, bit2 (the ninth bit) and the holding register are updated after the ninth-bit sample. With SM2=1, a ninth bit of 0 leaves all of them unchanged.
- R8: When receive enable is 0 in modes 1 to 3, incoming frames change nothing.
- R9: A stop bit read as 0 sets the framing-error flag. When `fe_sel`=1, bit7 reads this flag, writing 0 to bit7 clears it, and writing 1 to bit7 leaves it set. No write to bit7 made while `fe_sel`=1 changes the mode.
- R10: In mode 0, writing data shifts the byte out on txd, LSB first. Each bit is held for a full sclk period and is valid at the rising edge of sclk. The sclk period is 12 clocks with SM2=0 and 4 clocks with SM2=1. The clock is low for the first half of each period and high at idle.
- R11: In mode 0, a control write that keeps the mode at 0 and writes receive enable=1 and receive flag=0, made while the shifter is idle, clocks in eight bits LSB first. Each bit is taken at the end of the sclk high phase. The receive flag and the holding register update after the eighth bit.
- R12: irq is 1 exactly when the receive flag or the transmit flag is set.
- R13: Reading data returns the last received byte and never the byte written for transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = control, 1 = data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| fe_sel | input | 1 | Makes bit7 the framing-error flag |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| sclk | output | 1 | Mode-0 shift clock |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things:
- Software does not change the mode or SM2 while a frame or a mode-0 transfer is in progress.
- `baud_tick` is a single-cycle pulse.
- Clearing flags goes through ordinary control writes.

The stimulus changes control only between transfers. It holds each serial bit for a full 16-tick bit time. It drives the mode-0 input only after it sees sclk fall, and it clears the receive flag after a mode-0 reception with receive enable at 0, so that no extra reception starts.

// File: rtl/sport_multimode.sv
module sport_multimode #(
  parameter int OVS      = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       fe_sel,
  input  logic       baud_tick,
  input  logic       rxd,
  output logic       txd,
  output logic       sclk,
  output logic       irq
);
  localparam int TW = $clog2(OVS);
  localparam int DW = $clog2(DIV_SLOW);
  localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] T_S0   = TW'(OVS/2 - 1);
  localparam logic [TW-1:0] T_S1   = TW'(OVS/2);
  localparam logic [TW-1:0] T_S2   = TW'(OVS/2 + 1);

  logic ri, ti, rb8, tb8, ren, sm2, sm1, sm0, fe;
  logic [7:0] rbuf;
  logic rx_s1, rx_s;

  wire       wr_ctl   = wr_en & ~addr;
  wire       wr_dat   = wr_en & addr;
  wire [1:0] mode     = {sm0, sm1};
  wire [1:0] nxt_mode = {fe_sel ? sm0 : wdata[7], wdata[6]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s  <= rx_s1;
    end
  end

  // mode 0 shifter
  logic          m0_busy, m0_rx;
  logic [7:0]    m0_sh;
  logic [DW-1:0] m0_cnt;
  logic [2:0]    m0_bit;
  wire  [DW-1:0] m0_last = sm2 ? DW'(DIV_FAST - 1) : DW'(DIV_SLOW - 1);
  wire  [DW-1:0] m0_half = sm2 ? DW'(DIV_FAST / 2) : DW'(DIV_SLOW / 2);
  wire           m0_end  = m0_busy && (m0_cnt == m0_last);
  wire           m0_done = m0_end && (m0_bit == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m0_busy <= 1'b0;
      m0_rx   <= 1'b0;
      m0_sh   <= '0;
      m0_cnt  <= '0;
      m0_bit  <= '0;
    end else if (!m0_busy) begin
      if (wr_dat && mode == 2'b00) begin
        m0_busy <= 1'b1;
        m0_rx   <= 1'b0;
        m0_sh   <= wdata;
        m0_cnt  <= '0;
        m0_bit  <= '0;
      end else if (wr_ctl && nxt_mode == 2'b00 && wdata[4] && !wdata[0]) begin
        m0_busy <= 1'b1;
        m0_rx   <= 1'b1;
        m0_cnt  <= '0;
        m0_bit  <= '0;
      end
    end else if (m0_end) begin
      m0_cnt <= '0;
      m0_sh  <= {m0_rx ? rx_s : 1'b0, m0_sh[7:1]};
      m0_bit <= m0_bit + 3'd1;
      if (m0_bit == 3'd7) m0_busy <= 1'b0;
    end else begin
      m0_cnt <= m0_cnt + DW'(1);
    end
  end

  assign sclk = m0_busy ? (m0_cnt >= m0_half) : 1'b1;

  // asynchronous transmitter
  logic          tx_busy;
  logic [10:0]   tx_sh;
  logic [3:0]    tx_bit;
  logic [TW-1:0] tx_tck;
  wire  [3:0]    tx_stop = sm0 ? 4'd10 : 4'd9;
  wire           tx_bend = tx_busy && baud_tick && (tx_tck == T_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_bit  <= '0;
      tx_tck  <= '0;
    end else if (!tx_busy) begin
      if (wr_dat && mode != 2'b00) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, sm0 ? tb8 : 1'b1, wdata, 1'b0};
        tx_bit  <= '0;
        tx_tck  <= '0;
      end
    end else if (baud_tick) begin
      if (tx_tck == T_LAST) begin
        tx_tck <= '0;
        tx_sh  <= {1'b1, tx_sh[10:1]};
        tx_bit <= tx_bit + 4'd1;
        if (tx_bit == tx_stop) tx_busy <= 1'b0;
      end else begin
        tx_tck <= tx_tck + TW'(1);
      end
    end
  end

  assign txd = (m0_busy && !m0_rx) ? m0_sh[0] : (tx_busy ? tx_sh[0] : 1'b1);

  // asynchronous receiver
  logic          rx_busy;
  logic [3:0]    rx_idx;
  logic [TW-1:0] rx_tck;
  logic [1:0]    rx_v;
  logic [7:0]    rx_sh;
  wire  [3:0]    rx_stop = sm0 ? 4'd10 : 4'd9;
  wire           rx_en   = ren && mode != 2'b00;
  wire           maj     = (rx_v[0] & rx_v[1]) | (rx_v[0] & rx_s) | (rx_v[1] & rx_s);
  wire           rx_mid  = rx_busy && baud_tick && (rx_tck == T_S2);
  wire           rx_9    = rx_mid && (rx_idx == 4'd9);
  wire           accept  = rx_9 && (!sm2 || maj);
  wire           fe_set  = rx_mid && (rx_idx == rx_stop) && !maj;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_idx  <= '0;
      rx_tck  <= '0;
      rx_v    <= '0;
      rx_sh   <= '0;
    end else if (!rx_en) begin
      rx_busy <= 1'b0;
    end else if (!rx_busy) begin
      if (baud_tick && !rx_s) begin
        rx_busy <= 1'b1;
        rx_tck  <= '0;
        rx_idx  <= '0;
      end
    end else if (baud_tick) begin
      rx_tck <= (rx_tck == T_LAST) ? '0 : rx_tck + TW'(1);
      if (rx_tck == T_S0) rx_v[0] <= rx_s;
      if (rx_tck == T_S1) rx_v[1] <= rx_s;
      if (rx_tck == T_S2) begin
        if (rx_idx != 4'd0 && rx_idx <= 4'd8) rx_sh <= {maj, rx_sh[7:1]};
        if ((rx_idx == 4'd0 && maj) || rx_idx == rx_stop) rx_busy <= 1'b0;
        rx_idx <= rx_idx + 4'd1;
      end
    end
  end

  // control and holding registers
  wire ti_set = tx_bend && (tx_bit == tx_stop - 4'd1) || (m0_done && !m0_rx);
  wire ri_set = accept || (m0_done && m0_rx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ri, ti, rb8, tb8, ren, sm2, sm1, sm0, fe} <= '0;
    end else begin
      if (wr_ctl) begin
        ri  <= wdata[0];
        ti  <= wdata[1];
        rb8 <= wdata[2];
        tb8 <= wdata[3];
        ren <= wdata[4];
        sm2 <= wdata[5];
        sm1 <= wdata[6];
        if (!fe_sel)        sm0 <= wdata[7];
        else if (!wdata[7]) fe  <= 1'b0;
      end
      if (ti_set) ti  <= 1'b1;
      if (ri_set) ri  <= 1'b1;
      if (accept) rb8 <= maj;
      if (fe_set) fe  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  rbuf <= '0;
    else if (accept)             rbuf <= rx_sh;
    else if (m0_done && m0_rx)   rbuf <= {rx_s, m0_sh[7:1]};
  end

  assign irq   = ri | ti;
  assign rdata = !rd_en ? 8'h00 :
                 addr   ? rbuf  : {fe_sel ? fe : sm0, sm1, sm2, ren, tb8, rb8, ti, ri};

  assert_ti_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !wr_ctl) |=> ti);
  assert_ri_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !wr_ctl) |=> ri);
  assert_addr_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_9 && sm0 && sm2 && !maj && !wr_ctl) |=> (ri == $past(ri)) && (rbuf == $past(rbuf)));
  assert_mode_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && fe_sel) |=> sm0 == $past(sm0));
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
endmodule

// File: tb/tb_sport_multimode.sv
module tb_sport_multimode;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, addr = 0;
  logic fe_sel = 0, baud_tick = 0, rxd = 1;
  logic [7:0] wdata = 0;
  wire  [7:0] rdata;
  wire  txd, sclk, irq;

  sport_multimode dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fe_sel(fe_sel), .baud_tick(baud_tick), .rxd(rxd),
    .txd(txd), .sclk(sclk), .irq(irq));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    baud_tick <= (cyc % 4 == 3);
  end

  int tests = 0, fails = 0;
  logic [7:0] last_rbuf = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1; d = rdata; rd_en = 0;
  endtask

  function automatic logic [7:0] ctl(input logic [1:0] m, input logic s2, input logic re, input logic t8);
    return {m[1], m[0], s2, re, t8, 3'b000};
  endfunction

  function automatic logic [10:0] frame(input logic [1:0] m, input logic [7:0] d, input logic b9, input logic stp);
    return (m == 2'd1) ? {1'b1, stp, d, 1'b0} : {stp, b9, d, 1'b0};
  endfunction

  function automatic int nbits(input logic [1:0] m);
    return (m == 2'd1) ? 10 : 11;
  endfunction

  function automatic logic accepts(input logic [1:0] m, input logic s2, input logic b9, input logic stp);
    return (m == 2'd1) ? (!s2 || stp) : (!s2 || b9);
  endfunction

  task automatic send(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = f[i];
      repeat (64) @(negedge clk);
    end
    rxd = 1;
    repeat (128) @(negedge clk);
  endtask

  task automatic cap(input int n, output logic [10:0] f, output logic irq_data, output logic irq_stop);
    f = '1; irq_data = 0; irq_stop = 0;
    while (txd) @(negedge clk);
    repeat (32) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      f[i] = txd;
      if (i == n - 2) irq_data = irq;
      if (i == n - 1) irq_stop = irq;
      if (i < n - 1) repeat (64) @(negedge clk);
    end
    repeat (48) @(negedge clk);
  endtask

  task automatic rx_case(input logic [1:0] m, input logic s2, input logic [7:0] d, input logic b9, input logic stp);
    logic [7:0] c, b;
    logic acc, e8;
    wr(0, ctl(m, s2, 1, 0));
    send(frame(m, d, b9, stp), nbits(m));
    acc = accepts(m, s2, b9, stp);
    e8  = acc ? ((m == 2'd1) ? stp : b9) : 1'b0;
    if (acc) last_rbuf = d;
    rd(0, c); rd(1, b);
    chk((m == 2'd1) ? "R6 rx flag" : "R7 rx flag", c[0], acc);
    chk((m == 2'd1) ? "R6 bit2" : "R7 bit2", c[2], e8);
    chk("R5 rx byte", b, last_rbuf);
    wr(0, ctl(m, 0, 0, 0));
  endtask

  task automatic tx_case(input logic [1:0] m, input logic [7:0] d, input logic t8);
    logic [10:0] f;
    logic a, z;
    logic [7:0] b;
    wr(0, ctl(m, 0, 0, t8));
    wr(1, d);
    cap(nbits(m), f, a, z);
    chk("R3 tx frame", f, frame(m, d, t8, 1'b1));
    chk("R4 tx flag before stop", a, 0);
    chk("R4 tx flag at stop", z, 1);
    rd(1, b);
    chk("R13 data read is rx side", b, last_rbuf);
    wr(0, ctl(m, 0, 0, t8));
  endtask

  task automatic m0_tx(input logic s2, input logic [7:0] d);
    logic [7:0] got;
    int t0, t1;
    got = 0; t0 = 0; t1 = 0;
    wr(0, ctl(0, s2, 0, 0));
    wr(1, d);
    for (int i = 0; i < 8; i++) begin
      while (sclk) @(negedge clk);
      while (!sclk) @(negedge clk);
      got[i] = txd;
      if (i == 0) t0 = cyc;
      if (i == 1) t1 = cyc;
    end
    chk("R10 m0 tx byte", got, d);
    chk("R10 sclk period", t1 - t0, s2 ? 4 : 12);
    chk("R4 m0 tx flag not yet", irq, 0);
    repeat (s2 ? 4 : 12) @(negedge clk);
    chk("R4 m0 tx flag set", irq, 1);
    chk("R10 sclk idle", sclk, 1);
    wr(0, ctl(0, s2, 0, 0));
  endtask

  task automatic m0_rx(input logic s2, input logic [7:0] d);
    logic [7:0] c, b;
    wr(0, ctl(0, s2, 1, 0));
    for (int i = 0; i < 8; i++) begin
      while (sclk) @(negedge clk);
      rxd = d[i];
      while (!sclk) @(negedge clk);
    end
    repeat (16) @(negedge clk);
    rxd = 1;
    rd(0, c); rd(1, b);
    chk("R11 m0 rx flag", c[0], 1);
    chk("R11 m0 rx byte", b, d);
    last_rbuf = d;
    wr(0, ctl(0, s2, 0, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [10:0] f;
    logic a, z;
    int lows;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst_n = 1;
    rd(0, v); chk("R1 control reset", v, 0);
    rd(1, v); chk("R1 data reset", v, 0);
    chk("R1 txd idle", txd, 1);
    chk("R1 sclk idle", sclk, 1);
    chk("R1 irq idle", irq, 0);

    wr(0, 8'hFF);
    rd(0, v); chk("R2 control readback", v, 8'hFF);
    chk("R12 irq both flags", irq, 1);
    @(negedge clk); addr = 0; #1; chk("R2 rdata without rd_en", rdata, 0);
    wr(0, 8'h01); chk("R12 irq rx flag", irq, 1);
    wr(0, 8'h02); chk("R12 irq tx flag", irq, 1);
    wr(0, 8'h00); chk("R12 irq clear", irq, 0);

    rx_case(2'd1, 0, 8'hA5, 0, 1);
    rx_case(2'd1, 1, 8'h3C, 0, 0);
    rx_case(2'd2, 1, 8'h81, 0, 1);
    rx_case(2'd2, 1, 8'h7E, 1, 1);
    rx_case(2'd3, 0, 8'h00, 0, 1);

    wr(0, ctl(1, 0, 0, 0));
    send(frame(1, 8'h55, 0, 1), 10);
    rd(0, v); chk("R8 disabled rx flag", v[0], 0);
    rd(1, v); chk("R8 disabled rx byte", v, last_rbuf);

    wr(0, ctl(1, 0, 1, 0));
    rxd = 0; repeat (16) @(negedge clk); rxd = 1;
    repeat (200) @(negedge clk);
    rd(0, v); chk("R5 false start ignored", v[0], 0);
    rx_case(2'd1, 0, 8'hC3, 0, 1);

    wr(0, ctl(1, 0, 1, 0));
    fe_sel = 1;
    send(frame(1, 8'h96, 0, 0), 10);
    last_rbuf = 8'h96;
    rd(0, v); chk("R9 fe set", v[7], 1);
    chk("R6 accept bad stop sm2=0", v[0], 1);
    chk("R6 bit2 holds stop", v[2], 0);
    wr(0, 8'hD0);
    rd(0, v); chk("R9 write 1 keeps fe", v[7], 1);
    wr(0, 8'h50);
    rd(0, v); chk("R9 write 0 clears fe", v[7], 0);
    fe_sel = 0;
    rd(0, v); chk("R9 mode bit unchanged", v, 8'h50);
    wr(0, 8'h00);

    m0_tx(0, 8'hB4);
    m0_tx(1, 8'h2D);
    m0_rx(0, 8'h6A);
    m0_rx(1, 8'hE1);

    wr(0, ctl(1, 0, 0, 0));
    wr(1, 8'h33);
    wr(1, 8'hCC);
    cap(10, f, a, z);
    chk("R3 busy write dropped", f, frame(1, 8'h33, 0, 1));
    lows = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R3 no second frame", lows, 0);
    wr(0, 8'h40);

    for (int k = 0; k < 12; k++) begin
      logic [1:0] m;
      m = 2'(1 + $urandom % 3);
      rx_case(m, 1'($urandom % 2), 8'($urandom), 1'($urandom % 2), ($urandom % 4) != 0);
    end
    for (int k = 0; k < 8; k++) begin
      logic [1:0] m;
      m = 2'(1 + $urandom % 3);
      tx_case(m, 8'($urandom), 1'($urandom % 2));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule